// File: doc/BRIEF.md
# Four-Channel DMA Programming Register Block

This block is the host-facing register file of a four-channel DMA controller. A host reaches it through an 8-bit port interface with a 4-bit offset. Each channel's 16-bit address and 16-bit transfer count pass through that byte-wide port in two accesses. A single byte pointer, shared by all channels, picks the half. The pointer flips after every address or count access, whether a read or a write. A dedicated port returns it to the low half.

Each channel holds a base and a current copy of its address and of its count. Writing a base also writes the current copy. A transfer engine, outside this block, pulses a per-channel `step` input once per completed transfer. On each step the current address goes up by one and the current count goes down by one. The count is programmed as the number of transfers minus one, so the step taken at a count of zero is the last one. That step wraps the count to 0xFFFF and raises a terminal-count flag. If the channel's auto-initialise bit is set, both current registers are instead reloaded from their bases.

The block also holds a mode byte per channel, a four-bit channel mask, a command byte, software request bits and a status byte. Global commands provide clear-pointer, master clear, clear-all-mask and write-all-mask.

Top module: `dmareg_top`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer is clear, the status byte reads 0x00, the command byte is 0x00, and every current address and count is 0x0000.
- R2: A write to offset 2n (address) or 2n+1 (count) of channel n stores the byte into the low half when the pointer is clear and into the high half when it is set. The write goes to both the base and the current copy. Every access at offsets 0 to 7 toggles the pointer.
- R3: A write of any value to offset 0xC clears the byte pointer, so the next address or count access targets the low half.
- R4: A read at offset 2n+1 returns the low or high byte of channel n's current count, chosen by the pointer. A read at offset 2n does the same for the current address.
- R5: A write to offset 0xA changes only the mask bit of the channel named in bits[1:0]. Bit 2 = 1 sets that mask bit and bit 2 = 0 clears it.
- R6: A write to offset 0xB stores the whole byte as the mode of the channel in bits[1:0]. Bit 4 of the mode is auto-initialise. Bits[3:2] give the direction (01 I/O to memory, 10 memory to I/O). Bits[7:6] give the mode (01 single, 11 cascade).
- R7: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask from data bits[3:0].
- R8: A step on a channel increments its current address and decrements its current count. A step at count 0x0000 leaves the count at 0xFFFF, sets that channel's terminal-count flag and clears its software request bit.
- R9: With auto-initialise set, the terminal-count step reloads the current address and count from their bases.
- R10: A read at offset 8 returns terminal-count flags in bits[3:0] and request-pending flags (software request OR `dreq`) in bits[7:4]. The read clears the terminal-count flags.
- R11: A write to offset 0xD sets all mask bits and clears the byte pointer, the terminal-count flags, the software requests and the command byte.
- R12: A write to offset 9 sets (bit 2 = 1) or clears (bit 2 = 0) the software request bit of the channel in bits[1:0].
- R13: A write to offset 8 loads the command byte, which appears on `cmd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe |
| addr | input | 4 | Port offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| step | input | 4 | Per-channel transfer-done pulse from the engine |
| dreq | input | 4 | Per-channel hardware request level |
| cur_addr_o | output | 64 | Current addresses, channel n at [16n+15:16n] |
| cur_cnt_o | output | 64 | Current counts, channel n at [16n+15:16n] |
| mode_o | output | 32 | Mode bytes, channel n at [8n+7:8n] |
| mask_o | output | 4 | Channel mask bits |
| sw_req_o | output | 4 | Software request bits |
| tc_flag_o | output | 4 | Terminal-count flags |
| cmd_o | output | 8 | Command byte |

## Verification
The assertions assume that a channel's `step` pulse never lands in the same cycle as a port write, and that `wr_en` and `rd_en` are never high together. The step and status checks are written only for cycles where those inputs keep apart. The bench drives every port access and every step from its own task, each task owning whole cycles, so a step never coincides with a register access. The pointer is always cleared through offset 0xC before a 16-bit value is programmed or read back.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int DW = 8;
  localparam int OFS_CMD     = 8;
  localparam int OFS_REQ     = 9;
  localparam int OFS_SMASK   = 10;
  localparam int OFS_MODE    = 11;
  localparam int OFS_CLRPTR  = 12;
  localparam int OFS_MCLR    = 13;
  localparam int OFS_CLRMASK = 14;
  localparam int OFS_ALLMASK = 15;

  typedef struct packed {
    logic chan_acc;
    logic chan_wr;
    logic is_cnt;
    logic [1:0] chan;
    logic cmd_wr;
    logic stat_rd;
    logic req_wr;
    logic smask_wr;
    logic mode_wr;
    logic clrptr_wr;
    logic mclr_wr;
    logic clrmask_wr;
    logic allmask_wr;
  } strobe_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  output strobe_t    strb
);
  always_comb begin
    strb            = '0;
    strb.chan       = addr[2:1];
    strb.is_cnt     = addr[0];
    strb.chan_acc   = (wr_en | rd_en) & ~addr[3];
    strb.chan_wr    = wr_en & ~addr[3];
    strb.stat_rd    = rd_en & (32'(addr) == OFS_CMD);
    if (wr_en) begin
      case (32'(addr))
        OFS_CMD:     strb.cmd_wr     = 1'b1;
        OFS_REQ:     strb.req_wr     = 1'b1;
        OFS_SMASK:   strb.smask_wr   = 1'b1;
        OFS_MODE:    strb.mode_wr    = 1'b1;
        OFS_CLRPTR:  strb.clrptr_wr  = 1'b1;
        OFS_MCLR:    strb.mclr_wr    = 1'b1;
        OFS_CLRMASK: strb.clrmask_wr = 1'b1;
        OFS_ALLMASK: strb.allmask_wr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          hi,
  input  logic [BW-1:0] wdata,
  input  logic          mode_wr,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic [BW-1:0] mode,
  output logic          tc
);
  localparam int AUTO_BIT = 4;

  logic [AW-1:0] base_addr_q, base_addr_d;
  logic [AW-1:0] base_cnt_q, base_cnt_d;
  logic [AW-1:0] cur_addr_q, cur_addr_d;
  logic [AW-1:0] cur_cnt_q, cur_cnt_d;
  logic [BW-1:0] mode_q;
  logic          load_en, step_en;

  assign tc      = step & (cur_cnt_q == '0);
  assign load_en = wr_addr | wr_cnt;
  assign step_en = step & ~load_en;

  function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] v,
                                             input logic hsel,
                                             input logic [BW-1:0] b);
    logic [AW-1:0] r;
    r = v;
    if (hsel) r[AW-1:AW-BW] = b;
    else      r[BW-1:0]     = b;
    return r;
  endfunction

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_addr_d  = cur_addr_q;
    cur_cnt_d   = cur_cnt_q;
    if (wr_addr) begin
      base_addr_d = put_byte(base_addr_q, hi, wdata);
      cur_addr_d  = put_byte(cur_addr_q, hi, wdata);
    end
    if (wr_cnt) begin
      base_cnt_d = put_byte(base_cnt_q, hi, wdata);
      cur_cnt_d  = put_byte(cur_cnt_q, hi, wdata);
    end
    if (step_en) begin
      if (tc && mode_q[AUTO_BIT]) begin
        cur_addr_d = base_addr_q;
        cur_cnt_d  = base_cnt_q;
      end else begin
        cur_addr_d = cur_addr_q + 1'b1;
        cur_cnt_d  = cur_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else if (load_en | step_en) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= wdata;
  end

  assign cur_addr = cur_addr_q;
  assign cur_cnt  = cur_cnt_q;
  assign mode     = mode_q;
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NCH-1:0]   step,
  input  logic [NCH-1:0]   dreq,
  output logic [NCH*AW-1:0] cur_addr_o,
  output logic [NCH*AW-1:0] cur_cnt_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic [NCH-1:0]   mask_o,
  output logic [NCH-1:0]   sw_req_o,
  output logic [NCH-1:0]   tc_flag_o,
  output logic [DW-1:0]    cmd_o
);
  localparam int CHW = 2;
  localparam int SET_BIT = 2;

  logic       rst_s1, rst_sync_n;
  strobe_t    strb;
  logic       ptr_q, ptr_d, ptr_en;
  logic [NCH-1:0] mask_q, mask_d;
  logic [NCH-1:0] req_q, req_d;
  logic [NCH-1:0] tcf_q, tcf_d;
  logic [NCH-1:0] tc_set;
  logic [DW-1:0]  cmd_q;
  logic [CHW-1:0] wch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  dmareg_decode u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .strb  (strb)
  );

  assign wch = wdata[CHW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_w;
    assign sel_w = strb.chan_wr & (32'(strb.chan) == g);
    dmareg_chan #(.AW(AW), .BW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_addr  (sel_w & ~strb.is_cnt),
      .wr_cnt   (sel_w & strb.is_cnt),
      .hi       (ptr_q),
      .wdata    (wdata),
      .mode_wr  (strb.mode_wr & (32'(wch) == g)),
      .step     (step[g]),
      .cur_addr (cur_addr_o[g*AW +: AW]),
      .cur_cnt  (cur_cnt_o[g*AW +: AW]),
      .mode     (mode_o[g*DW +: DW]),
      .tc       (tc_set[g])
    );
  end

  // byte pointer
  always_comb begin
    ptr_en = strb.chan_acc | strb.clrptr_wr | strb.mclr_wr;
    ptr_d  = (strb.clrptr_wr | strb.mclr_wr) ? 1'b0 : ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ptr_q <= 1'b0;
    else if (ptr_en)  ptr_q <= ptr_d;
  end

  // mask, requests, terminal-count flags
  always_comb begin
    mask_d = mask_q;
    req_d  = req_q;
    tcf_d  = tcf_q;
    if (strb.smask_wr)   mask_d[wch] = wdata[SET_BIT];
    if (strb.clrmask_wr) mask_d = '0;
    if (strb.allmask_wr) mask_d = wdata[NCH-1:0];
    if (strb.req_wr)     req_d[wch] = wdata[SET_BIT];
    req_d = req_d & ~tc_set;
    if (strb.stat_rd)    tcf_d = '0;
    tcf_d = tcf_d | tc_set;
    if (strb.mclr_wr) begin
      mask_d = '1;
      req_d  = '0;
      tcf_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '1;
      req_q  <= '0;
      tcf_q  <= '0;
    end else begin
      mask_q <= mask_d;
      req_q  <= req_d;
      tcf_q  <= tcf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)       cmd_q <= '0;
    else if (strb.mclr_wr) cmd_q <= '0;
    else if (strb.cmd_wr)  cmd_q <= wdata;
  end

  // read mux
  always_comb begin
    logic [AW-1:0] word;
    word  = strb.is_cnt ? cur_cnt_o[32'(strb.chan)*AW +: AW]
                        : cur_addr_o[32'(strb.chan)*AW +: AW];
    rdata = '0;
    if (rd_en) begin
      if (!addr[3])
        rdata = ptr_q ? word[AW-1:AW-DW] : word[DW-1:0];
      else if (strb.stat_rd)
        rdata = {req_q | dreq, tcf_q};
    end
  end

  assign mask_o    = mask_q;
  assign sw_req_o  = req_q;
  assign tc_flag_o = tcf_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [3:0]  step,
  input logic [15:0] cnt0,
  input logic [3:0]  mask,
  input logic [3:0]  tcf,
  input logic [3:0]  req,
  input logic [7:0]  cmd
);
  AST_MCLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hD) |=> (mask == 4'hF && req == 4'h0 && cmd == 8'h00)); // R11

  AST_CLR_ALL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hE) |=> (mask == 4'h0)); // R7

  AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] && !wr_en && cnt0 != 16'h0) |=> (cnt0 == $past(cnt0) - 16'h1)); // R8

  AST_TC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] && !wr_en && cnt0 == 16'h0) |=> (tcf[0] && !req[0])); // R8

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 4'h8 && step == 4'h0) |=> (tcf == 4'h0)); // R10
endmodule

bind dmareg_top dmareg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .step  (step),
  .cnt0  (cur_cnt_o[15:0]),
  .mask  (mask_o),
  .tcf   (tc_flag_o),
  .req   (sw_req_o),
  .cmd   (cmd_o)
);

// File: tb/dmareg_top_test.sv
module dmareg_top_test;
  logic        clk, rst_n, wr_en, rd_en;
  logic [3:0]  addr, step, dreq;
  logic [7:0]  wdata, rdata, cmd_o;
  logic [63:0] cur_addr_o, cur_cnt_o;
  logic [31:0] mode_o;
  logic [3:0]  mask_o, sw_req_o, tc_flag_o;
  int checks = 0, errors = 0;

  dmareg_top uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; #1;
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step = 4'b0001 << ch;
      @(negedge clk); step = 4'b0; #1;
    end
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    bus_wr(4'hC, 8'h00);
    bus_wr(a, v[7:0]);
    bus_wr(a, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 mask", mask_o, 4'hF);
    chk("R1 cmd", cmd_o, 8'h00);
    chk("R1 cnt", cur_cnt_o[31:0], 32'h0);
    chk("R1 addr", cur_addr_o[31:0], 32'h0);
    bus_rd(4'h8, d);
    chk("R1 status", d, 8'h00);
  endtask

  task automatic t_program;
    logic [7:0] d;
    wr16(4'h2, 16'h1234);
    chk("R2 addr ch1", cur_addr_o[31:16], 16'h1234);
    wr16(4'h3, 16'h0002);
    chk("R2 cnt ch1", cur_cnt_o[31:16], 16'h0002);
    bus_wr(4'hC, 8'h00);
    bus_rd(4'h3, d); chk("R4 cnt lo", d, 8'h02);
    bus_rd(4'h3, d); chk("R4 cnt hi", d, 8'h00);
    bus_rd(4'h2, d); chk("R4 addr lo", d, 8'h34);
    bus_rd(4'h2, d); chk("R4 addr hi", d, 8'h12);
  endtask

  task automatic t_clrptr;
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h2, 8'h77);
    bus_wr(4'hC, 8'h5A);
    bus_wr(4'h2, 8'hAB);
    chk("R3 low after clear", cur_addr_o[31:16], 16'h12AB);
    bus_wr(4'h2, 8'hCD);
    chk("R3 high next", cur_addr_o[31:16], 16'hCDAB);
  endtask

  task automatic t_step_tc;
    logic [7:0] d;
    bus_wr(4'h9, 8'h05);
    chk("R12 req set", sw_req_o, 4'b0010);
    bus_rd(4'h8, d); chk("R10 req pending", d, 8'h20);
    pulse(1, 1);
    chk("R8 cnt dec", cur_cnt_o[31:16], 16'h0001);
    chk("R8 addr inc", cur_addr_o[31:16], 16'hCDAC);
    pulse(1, 2);
    chk("R8 wrap", cur_cnt_o[31:16], 16'hFFFF);
    chk("R8 tc flag", tc_flag_o, 4'b0010);
    chk("R8 req cleared", sw_req_o, 4'b0000);
    dreq = 4'b1000;
    bus_rd(4'h8, d); chk("R10 status", d, 8'h82);
    bus_rd(4'h8, d); chk("R10 cleared", d, 8'h80);
    dreq = 4'b0;
    bus_wr(4'h9, 8'h07); bus_wr(4'h9, 8'h03);
    chk("R12 req clear", sw_req_o, 4'b0000);
  endtask

  task automatic t_autoinit;
    bus_wr(4'hB, 8'h56);
    chk("R6 mode ch2", mode_o[23:16], 8'h56);
    chk("R6 ch1 untouched", mode_o[15:8], 8'h00);
    wr16(4'h4, 16'h0100);
    wr16(4'h5, 16'h0000);
    pulse(2, 1);
    chk("R9 cnt reload", cur_cnt_o[47:32], 16'h0000);
    chk("R9 addr reload", cur_addr_o[47:32], 16'h0100);
    chk("R9 tc", tc_flag_o[2], 1'b1);
  endtask

  task automatic t_mask;
    bus_wr(4'hA, 8'h00); chk("R5 clr ch0", mask_o, 4'b1110);
    bus_wr(4'hA, 8'h02); chk("R5 clr ch2", mask_o, 4'b1010);
    bus_wr(4'hA, 8'h06); chk("R5 set ch2", mask_o, 4'b1110);
    bus_wr(4'hE, 8'hFF); chk("R7 clear all", mask_o, 4'b0000);
    bus_wr(4'hF, 8'h09); chk("R7 write all", mask_o, 4'b1001);
  endtask

  task automatic t_cmd_mclr;
    logic [7:0] d;
    bus_wr(4'h8, 8'hA5); chk("R13 cmd", cmd_o, 8'hA5);
    bus_wr(4'h9, 8'h04);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h0, 8'h99);
    bus_wr(4'hD, 8'h00);
    chk("R11 mask", mask_o, 4'hF);
    chk("R11 cmd", cmd_o, 8'h00);
    chk("R11 req", sw_req_o, 4'h0);
    bus_rd(4'h8, d); chk("R11 status", d, 8'h00);
    bus_wr(4'h0, 8'h11);
    bus_wr(4'h0, 8'h22);
    chk("R11 pointer", cur_addr_o[15:0], 16'h2211);
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        step = '0; dreq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        t_program();
        t_clrptr();
        t_step_tc();
        t_autoinit();
        t_mask();
        t_cmd_mclr();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule